// File: doc/BRIEF.md
# Card Clock Divider with Glitch-Free Ratio Switching

This block derives the clock driven onto a smart-card contact from the reference clock of the interface. A select pin picks one of two ratios: half the reference rate or a quarter of it. An enable from the power-up sequencer starts and stops the output. While the enable is off the output stays low. When the enable comes on, the output begins with a complete low phase. When the enable goes off, a high phase that is already under way runs to its full length before the output stops.

The select pin is asynchronous to the reference and passes through a synchronizer. A new ratio takes effect only where a high phase ends, which is also where a low phase starts. No phase is ever cut short, and a ratio change reaches the output within eight reference cycles. Every high phase and every low phase of the running clock lasts a whole number of reference cycles. Within one ratio both phases have the same length, so the duty cycle is exactly 50 percent.

Top module: `cardclk_div`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `card_clk` is low and the divider is stopped.
- R2: With `sel_fast` = 1 held steady and `en` = 1, `card_clk` is high for 1 reference cycle and low for 1, giving a period of 2 cycles (4 rising edges and 4 high cycles in any 8-cycle window).
- R3: With `sel_fast` = 0 held steady and `en` = 1, `card_clk` is high for 2 reference cycles and low for 2, giving a period of 4 cycles (4 rising edges and 8 high cycles in any 16-cycle window).
- R4: While `en` is low and `card_clk` is low, `card_clk` stays low, and toggling `sel_fast` has no effect on it.
- R5: After `sel_fast` changes while running, the divider uses the new ratio no more than 8 reference cycles later. The switch happens only when a high phase ends. Every high phase has the full length of the ratio that was in force when it began.
- R6: When `en` rises with the divider stopped, `card_clk` is low for one full low phase of the selected ratio before its first rising edge: 2 reference cycles at `sel_fast` = 0. `sel_fast` is taken two cycles late through the synchronizer.
- R7: If `en` falls during a high phase, that high phase still lasts its full length, and then `card_clk` stays low. If `en` falls during a low phase, `card_clk` has no further rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run request from the sequencer |
| sel_fast | input | 1 | Ratio select, asynchronous: 1 = divide by 2, 0 = divide by 4 |
| card_clk | output | 1 | Divided clock for the card contact |

## Verification
Two functions can act on the same edge. One is a ratio change that has reached the end of the synchronizer. The other is the enable, either falling at the end of a high phase or rising while the divider is stopped. The bench provokes both cases by toggling `sel_fast` in the same cycle that `en` changes. In the first case the stop must win, with no extra phase. In the second case the start latches the old synchronized ratio and takes up the new one one phase pair later. A behavioural model, fed with the same two-cycle-delayed select, judges every cycle, and window counts of high cycles and rising edges confirm the settled ratio.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

    // Ratio that is in force; the value matches the level of the select pin.
    typedef enum logic {
        RATIO_QUARTER = 1'b0,
        RATIO_HALF    = 1'b1
    } ratio_e;

    // Bit 1 drives the output directly, so the output is one flop.
    typedef enum logic [1:0] {
        PH_OFF  = 2'b00,
        PH_LOW  = 2'b01,
        PH_HIGH = 2'b10
    } phase_e;

    localparam int HALF_FAST_DEF   = 1;
    localparam int HALF_SLOW_DEF   = 2;
    localparam int SYNC_STAGES_DEF = 2;
    localparam int LAG_LIMIT       = 8;

    function automatic int phase_len(ratio_e r, int fast_len, int slow_len);
        return (r == RATIO_HALF) ? fast_len : slow_len;
    endfunction

endpackage

// File: rtl/cardclk_sync.sv
module cardclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cardclk_seq.sv
module cardclk_seq
    import cardclk_pkg::*;
#(
    parameter int HALF_FAST = HALF_FAST_DEF,
    parameter int HALF_SLOW = HALF_SLOW_DEF,
    parameter int CNT_W     = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  ratio_e           ratio_req,
    output phase_e           phase,
    output ratio_e           ratio_act,
    output logic [CNT_W-1:0] age
);
    localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(HALF_FAST - 1);
    localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(HALF_SLOW - 1);

    logic phase_end;
    assign phase_end = (age == ((ratio_act == RATIO_HALF) ? LAST_FAST : LAST_SLOW));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_OFF;
            ratio_act <= RATIO_QUARTER;
            age       <= '0;
        end else begin
            case (phase)
                PH_OFF: begin
                    age <= '0;
                    if (en) begin
                        phase     <= PH_LOW;
                        ratio_act <= ratio_req;
                    end
                end
                PH_LOW: begin
                    if (!en) begin
                        phase <= PH_OFF;
                        age   <= '0;
                    end else if (phase_end) begin
                        phase <= PH_HIGH;
                        age   <= '0;
                    end else begin
                        age <= age + CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (phase_end) begin
                        age <= '0;
                        if (en) begin
                            phase     <= PH_LOW;
                            ratio_act <= ratio_req;
                        end else begin
                            phase <= PH_OFF;
                        end
                    end else begin
                        age <= age + CNT_W'(1);
                    end
                end
                default: begin
                    phase <= PH_OFF;
                    age   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/cardclk_div.sv
module cardclk_div
    import cardclk_pkg::*;
#(
    parameter int HALF_FAST   = HALF_FAST_DEF,
    parameter int HALF_SLOW   = HALF_SLOW_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sel_fast,
    output logic card_clk
);
    localparam int CNT_W = (HALF_SLOW > 1) ? $clog2(HALF_SLOW) : 1;

    logic             sel_sync;
    ratio_e           ratio_req;
    ratio_e           ratio_act;
    phase_e           phase;
    logic [CNT_W-1:0] age;

    cardclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sel_fast),
        .q   (sel_sync)
    );

    assign ratio_req = ratio_e'(sel_sync);

    cardclk_seq #(
        .HALF_FAST (HALF_FAST),
        .HALF_SLOW (HALF_SLOW),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .ratio_req (ratio_req),
        .phase     (phase),
        .ratio_act (ratio_act),
        .age       (age)
    );

    // Output taken straight from a state flop bit: no decode glitch.
    assign card_clk = phase[1];
endmodule

// File: rtl/cardclk_div_chk.sv
module cardclk_div_chk
    import cardclk_pkg::*;
#(
    parameter int HALF_FAST = HALF_FAST_DEF,
    parameter int HALF_SLOW = HALF_SLOW_DEF,
    parameter int MAX_LAG   = LAG_LIMIT
) (
    input logic   clk,
    input logic   rst,
    input logic   en,
    input logic   sel_fast,
    input logic   card_clk,
    input phase_e phase,
    input ratio_e ratio_act
);
    logic [7:0] hi_run;
    logic [7:0] lo_run;
    logic [7:0] lag;
    logic [7:0] exp_len;

    assign exp_len = 8'(phase_len(ratio_act, HALF_FAST, HALF_SLOW));

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
            lo_run <= '0;
            lag    <= '0;
        end else begin
            hi_run <= card_clk ? ((hi_run == 8'hFF) ? hi_run : hi_run + 8'd1) : 8'd0;
            lo_run <= !card_clk ? ((lo_run == 8'hFF) ? lo_run : lo_run + 8'd1) : 8'd0;
            if (phase == PH_OFF || ((ratio_act == RATIO_HALF) == sel_fast))
                lag <= '0;
            else if (lag != 8'hFF)
                lag <= lag + 8'd1;
        end
    end

    // R1
    reset_low_chk: assert property (@(posedge clk) rst |=> !card_clk);

    // R2 R3 R7
    high_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!card_clk && $past(card_clk)) |-> (hi_run == $past(exp_len)));

    // R6
    low_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(card_clk) |-> (lo_run >= exp_len));

    // R4
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !card_clk) |=> !card_clk);

    // R5
    lag_bound_chk: assert property (@(posedge clk) disable iff (rst)
        lag <= 8'(MAX_LAG));
endmodule

bind cardclk_div cardclk_div_chk #(
    .HALF_FAST (HALF_FAST),
    .HALF_SLOW (HALF_SLOW)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .sel_fast  (sel_fast),
    .card_clk  (card_clk),
    .phase     (phase),
    .ratio_act (ratio_act)
);

// File: tb/cardclk_div_test.sv
module cardclk_div_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic sel_fast = 1'b0;
    logic card_clk;

    int errors = 0;
    int checks = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    cardclk_div uut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .sel_fast (sel_fast),
        .card_clk (card_clk)
    );

    // Behavioural reference: select seen two edges late, halves 1 or 2.
    int hist[$] = '{0, 0};
    bit m_run = 0;
    bit m_lvl = 0;
    int m_half = 2;
    int m_age = 0;

    always @(posedge clk) begin
        int use_s;
        if (rst) begin
            hist = '{0, 0};
            m_run = 0; m_lvl = 0; m_half = 2; m_age = 0;
        end else begin
            use_s = hist[0];
            void'(hist.pop_front());
            hist.push_back(int'(sel_fast));
            if (!m_run) begin
                if (en) begin
                    m_run = 1; m_lvl = 0; m_half = use_s ? 1 : 2; m_age = 1;
                end
            end else if (!m_lvl) begin
                if (!en) m_run = 0;
                else if (m_age >= m_half) begin m_lvl = 1; m_age = 1; end
                else m_age++;
            end else begin
                if (m_age >= m_half) begin
                    if (en) begin m_lvl = 0; m_half = use_s ? 1 : 2; m_age = 1; end
                    else begin m_run = 0; m_lvl = 0; end
                end else m_age++;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (card_clk !== m_lvl) begin
                errors++;
                $display("FAIL %s per-cycle: card_clk=%0b expected %0b", tag, card_clk, m_lvl);
            end
        end
    end

    task automatic chk(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    task automatic win(input int n, output int highs, output int rises);
        bit prev;
        prev = card_clk;
        highs = 0;
        rises = 0;
        repeat (n) begin
            @(negedge clk);
            if (card_clk) highs++;
            if (card_clk && !prev) rises++;
            prev = card_clk;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int h, r, hi;
        repeat (3) @(negedge clk);
        chk("R1 reset level", int'(card_clk), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", int'(card_clk), 0);

        // R4: toggling the select while disabled
        tag = "R4";
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            sel_fast = ~sel_fast;
            if (card_clk) hi++;
        end
        sel_fast = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 idle highs", hi + int'(card_clk), 0);

        // R6: start from stopped, divide by 4
        tag = "R6";
        en = 1'b1;
        @(negedge clk); chk("R6 first low", int'(card_clk), 0);
        @(negedge clk); chk("R6 second low", int'(card_clk), 0);
        @(negedge clk); chk("R6 first rise", int'(card_clk), 1);

        tag = "R3";
        win(16, h, r);
        chk("R3 highs in 16", h, 8);
        chk("R3 rises in 16", r, 4);

        // R5: switch to fast
        tag = "R5";
        sel_fast = 1'b1;
        repeat (8) @(negedge clk);
        win(8, h, r);
        chk("R5 to fast highs", h, 4);
        chk("R5 to fast rises", r, 4);

        tag = "R2";
        win(16, h, r);
        chk("R2 highs in 16", h, 8);
        chk("R2 rises in 16", r, 8);

        // R5: switch back to slow
        tag = "R5";
        sel_fast = 1'b0;
        repeat (8) @(negedge clk);
        win(16, h, r);
        chk("R5 to slow highs", h, 8);
        chk("R5 to slow rises", r, 4);

        // R7: drop enable in the first cycle of a high phase
        tag = "R7";
        while (card_clk) @(negedge clk);
        while (!card_clk) @(negedge clk);
        en = 1'b0;
        @(negedge clk); chk("R7 high completes", int'(card_clk), 1);
        @(negedge clk); chk("R7 low after stop", int'(card_clk), 0);
        win(10, h, r);
        chk("R7 stays low after high", h, 0);

        // R7: drop enable during a low phase
        en = 1'b1;
        while (!card_clk) @(negedge clk);
        while (card_clk) @(negedge clk);
        en = 1'b0;
        win(10, h, r);
        chk("R7 no rise after low stop", r, 0);

        // Same cycle: select change together with stop, then with start
        tag = "R5";
        sel_fast = 1'b1;
        en = 1'b1;
        repeat (12) @(negedge clk);
        en = 1'b0;
        sel_fast = 1'b0;
        repeat (3) @(negedge clk);
        win(6, h, r);
        chk("R5 stop with select change", h, 0);
        en = 1'b1;
        sel_fast = 1'b1;
        repeat (12) @(negedge clk);
        win(8, h, r);
        chk("R5 start with select change rises", r, 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule